// File: doc/BRIEF.md
# Byte-strobe SRAM bus controller

This block drives an external static RAM built from 16-bit devices that have separate upper-byte and lower-byte select inputs. The per-byte write strobes are wired to those byte selects. On a read in a byte-control area the controller pulses only the strobes of the lanes being read. That lets the memory enable exactly the requested bytes on the data bus. Writes use the same strobes with the usual write timing. Each strobe turns on at a falling clock edge and turns off at a rising clock edge.

The host presents an address, an access size, a direction, a wait-state count and a line-transfer flag. A line transfer moves one 32-byte line as a burst of bus-width beats. The burst starts at the requested word and wraps inside the aligned line. Chip select stays low for the whole burst. The host gets a one-cycle acknowledge per beat, with read data valid in that cycle. For writes, the host holds the data word for the current beat and replaces it after each acknowledge.

The top three address bits name an area. Byte-control read behaviour can be enabled for two designated areas (1 and 4) only. If the multiplexed-bus setting of such an area is set, that area is excluded. In every other case reads leave all strobes inactive.

The controller is a four-state machine:
- IDLE: waits for a request. It goes to ADDR when `req_valid` is sampled.
- ADDR: one cycle of address setup per beat. It always goes to STRB.
- STRB: the strobe phase. It lasts `cfg_wait`+1 cycles. It then goes to ADDR when beats remain, or to TAIL after the last beat.
- TAIL: one cycle with chip select still low. It goes to IDLE.

Top module: `bsc_ctrl`

## Requirements
- R1: After reset `mem_cs_n`, `mem_rd_n` and all `mem_we_n` bits are high, and `ack` and `busy` are low.
- R2: A read in a byte-control area asserts only the strobes of the lanes read, in little-endian order. Lane k carries data bits 8k+7..8k. Size code 0 is a byte and asserts 1 strobe at offset `addr[1:0]`. Size code 1 is a halfword and asserts 2 strobes starting at `addr[1:0]`. Size code 2 is a word and asserts all 4 strobes.
- R3: In every beat that drives strobes, each active strobe is asserted on a falling clock edge and released on a rising clock edge.
- R4: A write asserts the strobes of the addressed lanes in any area and drives `req_wdata` on `mem_dq_o`, with `mem_dq_oe` high and `mem_rw_n` low.
- R5: A read outside byte-control mode leaves every `mem_we_n` bit high.
- R6: The area is `addr[31:29]`. Byte-control mode applies only when the area is 1 with `cfg_bc_en[0]` set, or when the area is 4 with `cfg_bc_en[1]` set. In either case the matching `cfg_mux_en` bit must be clear.
- R7: `mem_addr` carries `addr[17:2]` of the current beat.
- R8: The strobe phase of each beat lasts `cfg_wait`+1 clock cycles. After each beat, `ack` pulses for exactly one cycle, and for reads `rdata` holds the captured bus word in that cycle.
- R9: A line transfer runs 8 beats with all strobes. Beat i addresses the line base plus ((`addr[4:2]`·4 + 4i) mod 32).
- R10: `mem_cs_n` stays low from the first beat to the end of the transfer, and `mem_rd_n` stays low for a whole read transfer. `mem_cs_n` goes high one cycle after the final `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, sampled in IDLE |
| req_addr | input | 32 | Byte address; bits 31:29 select the area |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 for write |
| req_line | input | 1 | 32-byte wrapping line transfer |
| req_wdata | input | 32 | Write data of the current beat, lane aligned |
| cfg_wait | input | 3 | Extra strobe-phase cycles per beat |
| cfg_bc_en | input | 2 | Byte-control enable for area 1 (bit 0) and area 4 (bit 1) |
| cfg_mux_en | input | 2 | Multiplexed-bus setting for the same two areas |
| busy | output | 1 | Transfer in progress |
| ack | output | 1 | One-cycle beat-complete pulse |
| rdata | output | 32 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_rw_n | output | 1 | Direction, low on writes |
| mem_we_n | output | 4 | Per-lane byte strobes, active low |
| mem_addr | output | 16 | External word address |
| mem_dq_o | output | 32 | Write data to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | 32 | Read data from memory |

## Verification
The bench first targets the lane mask of byte and halfword reads at every offset. A decoder that ignored the offset, or that ignored the mode, would enable the wrong bytes. It would also enable bytes on plain reads, where the strobes must stay inactive. Strobe edges are sampled a short time after each rising edge and after each falling edge. A strobe that turned on at the rising edge would be caught, and so would one that released at the falling edge. The bench also counts strobe-active samples to check that the wait count stretches the strobe phase.

Line reads and writes start in the middle of the line. A sequencer that did not wrap, or that wrapped across the line, would present the wrong addresses. The area tests cover a designated area with the multiplexed setting applied, and a designated area whose enable bit is clear. They would show whether the multiplexed override is respected. The bench also checks that chip select is released exactly one cycle after the last acknowledge.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_TAIL = 2'd3
    } bsc_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } bsc_size_e;
endpackage

// File: rtl/bsc_lane_dec.sv
module bsc_lane_dec #(
    parameter int BB = 4,
    parameter int LB = 2
) (
    input  logic [LB-1:0] off,
    input  logic [1:0]    size,
    input  logic          full,
    output logic [BB-1:0] lanes
);
    int nb;
    int first;

    always_comb begin
        nb    = 1 << size;
        first = int'(off);
        for (int i = 0; i < BB; i++) begin
            lanes[i] = full || (nb >= BB) || ((i >= first) && (i < first + nb));
        end
    end
endmodule

// File: rtl/bsc_area_sel.sv
module bsc_area_sel #(
    parameter int AREA_W = 3,
    parameter int AREA_A = 1,
    parameter int AREA_B = 4
) (
    input  logic [AREA_W-1:0] area,
    input  logic [1:0]        bc_en,
    input  logic [1:0]        mux_en,
    output logic              bc
);
    logic [1:0] hit;

    for (genvar g = 0; g < 2; g++) begin : g_area
        localparam int ID = (g == 0) ? AREA_A : AREA_B;
        assign hit[g] = (area == AREA_W'(ID)) && bc_en[g] && !mux_en[g];
    end

    assign bc = |hit;
endmodule

// File: rtl/bsc_beat_seq.sv
module bsc_beat_seq #(
    parameter int ADDR_W     = 32,
    parameter int BB         = 4,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              ld_line,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(BB);
    localparam logic [ADDR_W-1:0] ALIGN = ADDR_W'(BB - 1);
    localparam int LINE_BEATS = LINE_BYTES / BB;

    logic [ADDR_W-1:0] cur_q, wrap_q, wrap_d;
    logic [CNT_W-1:0]  left_q, beats_d;
    int                nb;

    always_comb begin
        nb = 1 << ld_size;
        if (ld_line) begin
            beats_d = CNT_W'(LINE_BEATS - 1);
            wrap_d  = ADDR_W'(LINE_BYTES - 1);
        end else if (nb > BB) begin
            beats_d = CNT_W'(nb / BB - 1);
            wrap_d  = ADDR_W'(nb - 1);
        end else begin
            beats_d = '0;
            wrap_d  = ALIGN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            wrap_q <= '0;
            left_q <= '0;
        end else if (load) begin
            cur_q  <= ld_line ? (ld_addr & ~ALIGN) : ld_addr;
            wrap_q <= wrap_d;
            left_q <= beats_d;
        end else if (advance) begin
            cur_q  <= (cur_q & ~wrap_q) | ((cur_q + STEP) & wrap_q);
            left_q <= left_q - 1'b1;
        end
    end

    assign cur_addr = cur_q;
    assign last     = (left_q == '0);
endmodule

// File: rtl/bsc_strobe_gen.sv
module bsc_strobe_gen #(
    parameter int BB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_act,
    input  logic          enable,
    input  logic [BB-1:0] lanes,
    output logic [BB-1:0] we_n
);
    // Falling-edge copy of the rising-edge phase: the AND turns on at the
    // falling edge and turns off with the rising-edge phase.
    logic act_fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) act_fall_q <= 1'b0;
        else        act_fall_q <= phase_act;
    end

    for (genvar i = 0; i < BB; i++) begin : g_lane
        assign we_n[i] = ~(lanes[i] & enable & phase_act & act_fall_q);
    end
endmodule

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
    import bsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BUS_W      = 32,
    parameter int EXT_AW     = 16,
    parameter int WAIT_W     = 3,
    parameter int LINE_BYTES = 32,
    parameter int AREA_W     = 3,
    parameter int AREA_A     = 1,
    parameter int AREA_B     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [1:0]        cfg_bc_en,
    input  logic [1:0]        cfg_mux_en,
    output logic              busy,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_rw_n,
    output logic [BUS_W/8-1:0] mem_we_n,
    output logic [EXT_AW-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [BUS_W-1:0]  mem_dq_i
);
    localparam int BB    = BUS_W / 8;
    localparam int LB    = $clog2(BB);
    localparam int CNT_W = $clog2(LINE_BYTES / BB) + 1;

    bsc_state_e state_q, state_d;
    logic [WAIT_W-1:0] wcnt_q, wait_q;
    logic              wr_q, line_q, bc_q, ack_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] rdata_q;
    logic              bc_d, start, strb_end, phase_act, last;
    logic [ADDR_W-1:0] cur_addr;
    logic [BB-1:0]     lanes;

    assign start    = (state_q == ST_IDLE) && req_valid;
    assign strb_end = (state_q == ST_STRB) && (wcnt_q == wait_q);

    bsc_area_sel #(.AREA_W(AREA_W), .AREA_A(AREA_A), .AREA_B(AREA_B)) u_area (
        .area   (req_addr[ADDR_W-1 -: AREA_W]),
        .bc_en  (cfg_bc_en),
        .mux_en (cfg_mux_en),
        .bc     (bc_d)
    );

    bsc_beat_seq #(.ADDR_W(ADDR_W), .BB(BB), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .advance  (strb_end && !last),
        .ld_addr  (req_addr),
        .ld_size  (req_size),
        .ld_line  (req_line),
        .cur_addr (cur_addr),
        .last     (last)
    );

    bsc_lane_dec #(.BB(BB), .LB(LB)) u_lane (
        .off   (cur_addr[LB-1:0]),
        .size  (size_q),
        .full  (line_q),
        .lanes (lanes)
    );

    bsc_strobe_gen #(.BB(BB)) u_strb (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_act (phase_act),
        .enable    (wr_q || bc_q),
        .lanes     (lanes),
        .we_n      (mem_we_n)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_STRB;
            ST_STRB: if (strb_end) state_d = last ? ST_TAIL : ST_ADDR;
            ST_TAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and per-transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            wait_q  <= '0;
            wr_q    <= 1'b0;
            line_q  <= 1'b0;
            bc_q    <= 1'b0;
            size_q  <= 2'd0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= strb_end;
            if (start) begin
                wait_q <= cfg_wait;
                wr_q   <= req_write;
                line_q <= req_line;
                bc_q   <= bc_d;
                size_q <= req_size;
            end
            if (state_q == ST_STRB && !strb_end) wcnt_q <= wcnt_q + 1'b1;
            else                                 wcnt_q <= '0;
        end
    end

    // Read data capture at the rising edge that ends each read beat
    if (BUS_W == DATA_W) begin : g_rd_full
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 rdata_q <= '0;
            else if (strb_end && !wr_q) rdata_q <= mem_dq_i;
        end
        assign mem_dq_o = req_wdata;
    end else begin : g_rd_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 rdata_q <= '0;
            else if (strb_end && !wr_q) rdata_q[int'(cur_addr[LB]) * BUS_W +: BUS_W] <= mem_dq_i;
        end
        assign mem_dq_o = req_wdata[int'(cur_addr[LB]) * BUS_W +: BUS_W];
    end

    // Outputs decoded from the registered state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        phase_act = (state_q == ST_STRB);
        mem_cs_n  = !busy;
        mem_rd_n  = !(busy && !wr_q);
        mem_rw_n  = !(busy && wr_q);
        mem_dq_oe = busy && wr_q;
        mem_addr  = cur_addr[LB +: EXT_AW];
        ack       = ack_q;
        rdata     = rdata_q;
    end
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int BB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic [BB-1:0] we_n,
    input logic          ack,
    input logic          wr_q,
    input logic          bc_q
);
    a_r5_plain_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_q && !bc_q) |-> (&we_n));

    a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~we_n) == 0) || ($countones(~we_n) == 1) ||
        ($countones(~we_n) == 2) || ($countones(~we_n) == BB));

    a_r3_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&we_n)) |-> !cs_n);

    a_r8_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r10_cs_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(ack));

    a_r10_rd_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $fell(cs_n));
endmodule

bind bsc_ctrl bsc_checker #(.BB(BB)) u_bsc_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (mem_cs_n),
    .rd_n  (mem_rd_n),
    .we_n  (mem_we_n),
    .ack   (ack),
    .wr_q  (wr_q),
    .bc_q  (bc_q)
);

// File: tb/tb_bsc_ctrl.sv
`timescale 1ns/100ps
module tb_bsc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_line = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  cfg_wait = '0;
    logic [1:0]  cfg_bc_en = '0;
    logic [1:0]  cfg_mux_en = '0;
    logic        busy, ack;
    logic [31:0] rdata;
    logic        mem_cs_n, mem_rd_n, mem_rw_n, mem_dq_oe;
    logic [3:0]  mem_we_n;
    logic [15:0] mem_addr;
    logic [31:0] mem_dq_o, mem_dq_i;

    always #2.5 clk = ~clk;

    bsc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_line(req_line),
        .req_wdata(req_wdata), .cfg_wait(cfg_wait), .cfg_bc_en(cfg_bc_en),
        .cfg_mux_en(cfg_mux_en), .busy(busy), .ack(ack), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_rw_n(mem_rw_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [31:0] mem_fn(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction
    assign mem_dq_i = mem_fn(mem_addr);

    function automatic logic [31:0] wdata_fn(input int i);
        return 32'h11223344 + 32'h10101010 * i;
    endfunction

    typedef struct {
        logic [15:0] ea;
        logic [3:0]  lanes;
        logic        wr;
        logic [31:0] data;
        int          act;
        logic        last;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   nchk = 0;
    int   nfail = 0;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor state
    logic [3:0]  seen_lanes = '0;
    logic [31:0] seen_data = '0;
    int          seen_act = 0;
    logic [15:0] seen_addr = '0;
    logic [3:0]  neg_act = '0, pos_act = '0;
    bit          timing_bad = 0, glitch = 0, pend_rel = 0, cur_rd = 0;

    always @(negedge clk) begin
        logic [3:0] a;
        #1;
        a = ~mem_we_n;
        if (a != 4'h0) begin
            seen_lanes |= a;
            seen_act++;
            for (int k = 0; k < 4; k++)
                if (a[k]) seen_data[8*k +: 8] = mem_dq_o[8*k +: 8];
        end
        if (!mem_cs_n && !ack) seen_addr = mem_addr;
        if (a == 4'h0 && pos_act != 4'h0) timing_bad = 1;
        neg_act = a;
    end

    always @(posedge clk) begin
        logic [3:0] a;
        exp_t e;
        #1;
        a = ~mem_we_n;
        if (a != 4'h0 && neg_act == 4'h0) timing_bad = 1;
        pos_act = a;
        if (pend_rel) begin
            check(mem_cs_n && !busy, "R10", "cs release one cycle after last ack",
                  {31'd0, mem_cs_n}, 32'd1);
            pend_rel = 0;
        end
        if (busy && mem_cs_n) glitch = 1;
        if (busy && cur_rd && mem_rd_n) glitch = 1;
        if (ack) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected ack", 32'd1, 32'd0);
            end else begin
                e = q.pop_front();
                check(seen_addr == e.ea, e.tag, "R7 address", {16'd0, seen_addr}, {16'd0, e.ea});
                check(seen_lanes == e.lanes, e.tag, "lane mask", {28'd0, seen_lanes}, {28'd0, e.lanes});
                check(seen_act == e.act, e.tag, "R8 strobe cycles", seen_act, e.act);
                check(!timing_bad, e.tag, "R3 strobe edges", {31'd0, timing_bad}, 32'd0);
                if (e.wr) begin
                    for (int k = 0; k < 4; k++)
                        if (e.lanes[k])
                            check(seen_data[8*k +: 8] == e.data[8*k +: 8], e.tag,
                                  "R4 write lane data", seen_data, e.data);
                end else begin
                    check(rdata == e.data, e.tag, "R8 read data", rdata, e.data);
                end
                if (e.last) begin
                    check(!glitch && !mem_cs_n, "R10", "select held to last ack",
                          {31'd0, glitch}, 32'd0);
                    pend_rel = 1;
                end
            end
            seen_lanes = '0;
            seen_data  = '0;
            seen_act   = 0;
            timing_bad = 0;
        end
    end

    // Driver: pushes expected beats, then issues the request
    task automatic do_req(input logic [31:0] addr, input logic [1:0] size,
                          input logic wr, input logic line, input logic [2:0] wt,
                          input logic bc, input string tag);
        int beats = line ? 8 : 1;
        int got = 0;
        logic [4:0] start = {addr[4:2], 2'b00};
        for (int i = 0; i < beats; i++) begin
            exp_t e;
            logic [31:0] ba = line ? {addr[31:5], 5'(start + 5'(4 * i))} : addr;
            e.ea = ba[17:2];
            if (!(wr || bc))          e.lanes = 4'h0;
            else if (line || size == 2'd2) e.lanes = 4'hF;
            else if (size == 2'd1)    e.lanes = 4'h3 << ba[1:0];
            else                      e.lanes = 4'h1 << ba[1:0];
            e.wr   = wr;
            e.data = wr ? wdata_fn(i) : mem_fn(ba[17:2]);
            e.act  = (wr || bc) ? int'(wt) + 1 : 0;
            e.last = (i == beats - 1);
            e.tag  = tag;
            q.push_back(e);
        end
        while (busy || pend_rel) @(negedge clk);
        @(negedge clk);
        glitch    = 0;
        cur_rd    = !wr;
        req_addr  = addr;
        req_size  = size;
        req_write = wr;
        req_line  = line;
        cfg_wait  = wt;
        req_wdata = wdata_fn(0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (got < beats) begin
            @(posedge clk);
            #2;
            if (ack) begin
                got++;
                if (got < beats) req_wdata = wdata_fn(got);
            end
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(mem_cs_n && mem_rd_n && (mem_we_n == 4'hF) && !ack && !busy, "R1",
              "reset outputs", {mem_cs_n, mem_rd_n, mem_we_n, ack, busy}, 8'b11111100);

        cfg_bc_en  = 2'b11;
        cfg_mux_en = 2'b00;
        // R2: byte-control reads in area 1, several offsets and sizes
        do_req(32'h2000_0101, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, "R2");
        do_req(32'h2000_0403, 2'd0, 1'b0, 1'b0, 3'd1, 1'b1, "R2");
        do_req(32'h2000_0042, 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, "R2");
        do_req(32'h8000_0040, 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, "R2");
        // R8: word read with two wait states
        do_req(32'h2001_2344, 2'd2, 1'b0, 1'b0, 3'd2, 1'b1, "R8");
        // R5/R6: undesignated area reads give no strobes
        do_req(32'h6000_0010, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R5");
        // R6: multiplexed setting overrides area 4
        cfg_mux_en = 2'b10;
        do_req(32'h8000_0021, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, "R6");
        // R6: area 1 with its enable clear
        cfg_mux_en = 2'b00;
        cfg_bc_en  = 2'b10;
        do_req(32'h2000_0022, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, "R6");
        // R4: writes strobe in any area
        do_req(32'h6000_0033, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, "R4");
        do_req(32'h2000_0052, 2'd1, 1'b1, 1'b0, 3'd1, 1'b0, "R4");
        // R9/R10: wrapping line transfers
        cfg_bc_en = 2'b11;
        do_req(32'h8000_0314, 2'd2, 1'b0, 1'b1, 3'd0, 1'b1, "R9");
        do_req(32'h2000_051C, 2'd2, 1'b1, 1'b1, 3'd1, 1'b1, "R9");
        do_req(32'h6000_0008, 2'd2, 1'b0, 1'b1, 3'd0, 1'b0, "R10");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R8", "all beats acknowledged", q.size(), 0);
        finish_run();
    end
endmodule